// File: doc/BRIEF.md
# Linked-List Descriptor Fetcher for a DMA Channel

This block is the per-channel front end of a scatter-gather DMA engine. Software writes the address of the first descriptor into a control register and then sets the start bit. The block walks a chain of descriptors held in memory. It reads each descriptor one word at a time over a simple read port and loads the words into current-state registers. It then presents the transfer to a data mover through a valid/done handshake.

When the mover reports completion, the block pulses a per-descriptor event. It then follows the next pointer to the following descriptor. A fixed magic pointer value ends the chain. On that value the block raises a chain-complete event and returns to idle.

Software can freeze the channel without losing its state, resume it, or stop it outright. The current descriptor fields can be read back through the control interface. The remaining-count field is decremented as the mover reports progress. The decoded burst length, element width and address mode of both sides are driven to the mover alongside the handoff.

Top module: `chain_dma_fetch`

## Requirements
- R1: After reset the channel is idle: `mem_req`, `xfer_valid`, `desc_evt` and `chain_evt` are 0, and every register reads back 0.
- R2: Writing 1 to bit 0 of the register at offset 0x00 while idle starts the walk at the address held at offset 0x08, with bits 1:0 forced to 0. The six words of a descriptor are read at base+0, +4, +8, +12, +16 and +20, in that order, and no new request is issued while a read is outstanding.
- R3: The descriptor words are, in memory order: config, source address, destination address, byte length, parameter, next pointer. Config, source, destination, remaining count and parameter read back at offsets 0x0C, 0x10, 0x14, 0x18 and 0x1C.
- R4: Once the sixth word arrives, `xfer_valid` rises and stays high until a cycle in which `xfer_done` is sampled high. During that time `xfer_cfg`, `xfer_src`, `xfer_dst` and `xfer_len` carry the descriptor's values.
- R5: The remaining count is loaded with the byte length. Each cycle with `xfer_adv` high during a handoff reduces it by `xfer_adv_bytes`, and it saturates at 0.
- R6: Each side's fields in the config word are as follows. The source side is in bits 15:0 and the destination side in bits 31:16. In each side, bit 5 set means a fixed (I/O) address. Bits 8:7 give the burst: 0 gives 1 beat, 2 gives 8 beats, and any other code gives 0. Bits 10:9 give the width: 0, 1 and 2 give 1, 2 and 4 bytes, and 3 gives 0. Bits 4:0 carry the request line.
- R7: In the cycle after the accepting `xfer_done`, `desc_evt` is high for exactly one cycle. If the next pointer is not the end marker, fetching resumes at the next pointer with bits 1:0 cleared.
- R8: If the next pointer equals 0xFFFFF800, `chain_evt` pulses in the same cycle as `desc_evt` and the channel goes idle (bit 0 of offset 0x00 reads 0).
- R9: Writing 1 to bit 1 of offset 0x04 freezes the channel. While frozen it issues no memory request and holds `xfer_valid` low, but a read already outstanding is still accepted. Writing 0 resumes the walk with no word lost or repeated.
- R10: Writing 0 to bit 0 of offset 0x00 returns the channel to idle at the next edge and clears the pause bit. A read response that arrives afterwards is ignored, and no further request or handoff occurs.
- R11: A start write while the channel is busy is ignored, and the running chain continues unchanged.
- R12: Readback data appears one cycle after the read offset is applied. Offset 0x00 bit 0 reads busy, offset 0x04 bit 1 reads the pause state, offset 0x08 reads the address as written, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_off | input | 6 | Register write byte offset |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_off | input | 6 | Register read byte offset |
| cfg_rd_data | output | 32 | Registered read data |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| xfer_valid | output | 1 | Transfer offered to data mover |
| xfer_cfg | output | 32 | Raw config word |
| xfer_src | output | 32 | Source address |
| xfer_dst | output | 32 | Destination address |
| xfer_len | output | 32 | Remaining byte count |
| xfer_src_fixed | output | 1 | Source address does not increment |
| xfer_src_beats | output | 5 | Source burst length in beats |
| xfer_src_bytes | output | 3 | Source element width in bytes |
| xfer_dst_fixed | output | 1 | Destination address does not increment |
| xfer_dst_beats | output | 5 | Destination burst length in beats |
| xfer_dst_bytes | output | 3 | Destination element width in bytes |
| xfer_adv | input | 1 | Mover progress strobe |
| xfer_adv_bytes | input | 8 | Bytes moved with this strobe |
| xfer_done | input | 1 | Mover finished the transfer |
| desc_evt | output | 1 | One-cycle pulse per finished descriptor |
| chain_evt | output | 1 | One-cycle pulse when the chain ends |

## Verification
A three-descriptor chain uses misaligned first and next pointers. This separates correct alignment and word ordering from off-by-one address stepping. Its config words mix legal and reserved burst and width codes, so the decoder is checked against both. Progress strobes that leave the count positive or drive it past zero tell decrementing apart from saturating. Freezing before start and in the middle of a fetch shows whether requests are gated while an outstanding read is still accepted. A stop during a fetch, both plain and while frozen, followed by a late read response, shows whether stale data is discarded. A second start written while busy, with the first-address register already pointing elsewhere, exposes any restart.

// File: rtl/chain_dma_pkg.sv
`timescale 1ns/1ps
package chain_dma_pkg;
  localparam int OFF_W      = 6;
  localparam int DESC_WORDS = 6;

  // word order inside a descriptor in memory
  localparam int SLOT_CFG  = 0;
  localparam int SLOT_SRC  = 1;
  localparam int SLOT_DST  = 2;
  localparam int SLOT_LEN  = 3;
  localparam int SLOT_PARA = 4;
  localparam int SLOT_NEXT = 5;

  localparam logic [OFF_W-1:0] OFF_ENABLE = 6'h00;
  localparam logic [OFF_W-1:0] OFF_PAUSE  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_FIRST  = 6'h08;
  localparam logic [OFF_W-1:0] OFF_CFG    = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_SRC    = 6'h10;
  localparam logic [OFF_W-1:0] OFF_DST    = 6'h14;
  localparam logic [OFF_W-1:0] OFF_CNT    = 6'h18;
  localparam logic [OFF_W-1:0] OFF_PARA   = 6'h1C;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_HAND} seq_state_e;

  typedef struct packed {
    logic       fixed;
    logic [4:0] beats;
    logic [2:0] bytes;
  } side_dec_t;

  function automatic logic [4:0] burst_beats(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd2:    return 5'd8;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [2:0] width_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic side_dec_t decode_side(input logic [15:0] half);
    side_dec_t d;
    d.fixed = half[5];
    d.beats = burst_beats(half[8:7]);
    d.bytes = width_bytes(half[10:9]);
    return d;
  endfunction
endpackage

// File: rtl/chain_dma_regs.sv
`timescale 1ns/1ps
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [DW-1:0]    wr_data,
  input  logic [OFF_W-1:0] rd_off,
  input  logic             busy,
  input  logic [DW-1:0]    cur_cfg,
  input  logic [DW-1:0]    cur_src,
  input  logic [DW-1:0]    cur_dst,
  input  logic [DW-1:0]    cur_cnt,
  input  logic [DW-1:0]    cur_para,
  output logic             start_pulse,
  output logic             stop_pulse,
  output logic             paused,
  output logic [AW-1:0]    first_addr,
  output logic [DW-1:0]    rd_data
);
  logic en_wr, pause_wr;

  assign en_wr       = wr_en && (wr_off == OFF_ENABLE);
  assign pause_wr    = wr_en && (wr_off == OFF_PAUSE);
  assign start_pulse = en_wr && wr_data[0] && !busy;
  assign stop_pulse  = en_wr && !wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      paused     <= 1'b0;
      first_addr <= '0;
    end else begin
      if (stop_pulse)    paused <= 1'b0;
      else if (pause_wr) paused <= wr_data[1];
      if (wr_en && (wr_off == OFF_FIRST)) first_addr <= wr_data[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_off)
        OFF_ENABLE: rd_data <= {{(DW-1){1'b0}}, busy};
        OFF_PAUSE:  rd_data <= {{(DW-2){1'b0}}, paused, 1'b0};
        OFF_FIRST:  rd_data <= DW'(first_addr);
        OFF_CFG:    rd_data <= cur_cfg;
        OFF_SRC:    rd_data <= cur_src;
        OFF_DST:    rd_data <= cur_dst;
        OFF_CNT:    rd_data <= cur_cnt;
        OFF_PARA:   rd_data <= cur_para;
        default:    rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/chain_dma_seq.sv
`timescale 1ns/1ps
module chain_dma_seq
  import chain_dma_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            ADV_W    = 8,
  parameter logic [AW-1:0] END_MARK = 32'hFFFF_F800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             paused,
  input  logic [AW-1:0]    first_addr,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             xfer_valid,
  input  logic             xfer_done,
  input  logic             xfer_adv,
  input  logic [ADV_W-1:0] xfer_adv_bytes,
  output logic             busy,
  output logic [DW-1:0]    cur_cfg,
  output logic [DW-1:0]    cur_src,
  output logic [DW-1:0]    cur_dst,
  output logic [DW-1:0]    cur_cnt,
  output logic [DW-1:0]    cur_para,
  output logic             desc_evt,
  output logic             chain_evt
);
  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

  seq_state_e       st_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    ptr_q;
  logic [DW-1:0]    word_q [DESC_WORDS];
  logic             take_word, accept, at_end, adv_now;
  logic [AW-1:0]    next_ptr;

  assign take_word = (st_q == ST_WAIT) && mem_rvalid && !stop;
  assign accept    = (st_q == ST_HAND) && !paused && xfer_done;
  assign adv_now   = (st_q == ST_HAND) && xfer_adv && !stop;
  assign next_ptr  = word_q[SLOT_NEXT][AW-1:0];
  assign at_end    = (next_ptr == END_MARK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      ptr_q     <= '0;
      desc_evt  <= 1'b0;
      chain_evt <= 1'b0;
    end else begin
      desc_evt  <= 1'b0;
      chain_evt <= 1'b0;
      if (stop) begin
        st_q <= ST_IDLE;
      end else begin
        case (st_q)
          ST_IDLE: if (start) begin
            ptr_q <= {first_addr[AW-1:2], 2'b00};
            idx_q <= '0;
            st_q  <= ST_ISSUE;
          end
          ST_ISSUE: if (!paused) st_q <= ST_WAIT;
          ST_WAIT: if (mem_rvalid) begin
            if (idx_q == IDX_LAST) begin
              st_q <= ST_HAND;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_ISSUE;
            end
          end
          ST_HAND: if (accept) begin
            desc_evt <= 1'b1;
            if (at_end) begin
              chain_evt <= 1'b1;
              st_q      <= ST_IDLE;
            end else begin
              ptr_q <= {next_ptr[AW-1:2], 2'b00};
              idx_q <= '0;
              st_q  <= ST_ISSUE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_slot
    logic [DW-1:0] w_q;
    if (g == SLOT_LEN) begin : g_count
      always_ff @(posedge clk) begin
        if (rst) begin
          w_q <= '0;
        end else if (take_word && (idx_q == IDX_W'(g))) begin
          w_q <= mem_rdata;
        end else if (adv_now) begin
          w_q <= (w_q < DW'(xfer_adv_bytes)) ? '0 : w_q - DW'(xfer_adv_bytes);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          w_q <= '0;
        end else if (take_word && (idx_q == IDX_W'(g))) begin
          w_q <= mem_rdata;
        end
      end
    end
    assign word_q[g] = w_q;
  end

  assign mem_req    = (st_q == ST_ISSUE) && !paused;
  assign mem_addr   = ptr_q + AW'({idx_q, 2'b00});
  assign xfer_valid = (st_q == ST_HAND) && !paused;
  assign busy       = (st_q != ST_IDLE);
  assign cur_cfg    = word_q[SLOT_CFG];
  assign cur_src    = word_q[SLOT_SRC];
  assign cur_dst    = word_q[SLOT_DST];
  assign cur_cnt    = word_q[SLOT_LEN];
  assign cur_para   = word_q[SLOT_PARA];
endmodule

// File: rtl/chain_dma_fetch.sv
`timescale 1ns/1ps
module chain_dma_fetch
  import chain_dma_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            ADV_W    = 8,
  parameter logic [AW-1:0] END_MARK = 32'hFFFF_F800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr_en,
  input  logic [OFF_W-1:0] cfg_wr_off,
  input  logic [DW-1:0]    cfg_wr_data,
  input  logic [OFF_W-1:0] cfg_rd_off,
  output logic [DW-1:0]    cfg_rd_data,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_rvalid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             xfer_valid,
  output logic [DW-1:0]    xfer_cfg,
  output logic [DW-1:0]    xfer_src,
  output logic [DW-1:0]    xfer_dst,
  output logic [DW-1:0]    xfer_len,
  output logic             xfer_src_fixed,
  output logic [4:0]       xfer_src_beats,
  output logic [2:0]       xfer_src_bytes,
  output logic             xfer_dst_fixed,
  output logic [4:0]       xfer_dst_beats,
  output logic [2:0]       xfer_dst_bytes,
  input  logic             xfer_adv,
  input  logic [ADV_W-1:0] xfer_adv_bytes,
  input  logic             xfer_done,
  output logic             desc_evt,
  output logic             chain_evt
);
  logic          start_w, stop_w, paused_w, busy_w;
  logic [AW-1:0] first_w;
  logic [DW-1:0] cfg_w, src_w, dst_w, cnt_w, para_w;
  side_dec_t     src_dec, dst_dec;

  chain_dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .wr_off(cfg_wr_off), .wr_data(cfg_wr_data),
    .rd_off(cfg_rd_off), .busy(busy_w),
    .cur_cfg(cfg_w), .cur_src(src_w), .cur_dst(dst_w), .cur_cnt(cnt_w), .cur_para(para_w),
    .start_pulse(start_w), .stop_pulse(stop_w), .paused(paused_w),
    .first_addr(first_w), .rd_data(cfg_rd_data)
  );

  chain_dma_seq #(.AW(AW), .DW(DW), .ADV_W(ADV_W), .END_MARK(END_MARK)) u_seq (
    .clk(clk), .rst(rst),
    .start(start_w), .stop(stop_w), .paused(paused_w), .first_addr(first_w),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_done(xfer_done),
    .xfer_adv(xfer_adv), .xfer_adv_bytes(xfer_adv_bytes),
    .busy(busy_w),
    .cur_cfg(cfg_w), .cur_src(src_w), .cur_dst(dst_w), .cur_cnt(cnt_w), .cur_para(para_w),
    .desc_evt(desc_evt), .chain_evt(chain_evt)
  );

  assign src_dec        = decode_side(cfg_w[15:0]);
  assign dst_dec        = decode_side(cfg_w[31:16]);
  assign xfer_cfg       = cfg_w;
  assign xfer_src       = src_w;
  assign xfer_dst       = dst_w;
  assign xfer_len       = cnt_w;
  assign xfer_src_fixed = src_dec.fixed;
  assign xfer_src_beats = src_dec.beats;
  assign xfer_src_bytes = src_dec.bytes;
  assign xfer_dst_fixed = dst_dec.fixed;
  assign xfer_dst_beats = dst_dec.beats;
  assign xfer_dst_bytes = dst_dec.bytes;
endmodule

// File: rtl/chain_dma_fetch_chk.sv
`timescale 1ns/1ps
module chain_dma_fetch_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_wr_en,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          xfer_valid,
  input logic          xfer_done,
  input logic [DW-1:0] xfer_src,
  input logic [DW-1:0] xfer_dst,
  input logic          paused,
  input logic          desc_evt,
  input logic          chain_evt
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req); // R2
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R2
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_done && !cfg_wr_en) |=> xfer_valid); // R4
  AST_HANDOFF_STABLE: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_done) |=> (!xfer_valid || ($stable(xfer_src) && $stable(xfer_dst)))); // R4
  AST_DESC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    desc_evt |=> !desc_evt); // R7
  AST_DESC_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    desc_evt |-> $past(xfer_valid && xfer_done)); // R7
  AST_CHAIN_WITH_DESC: assert property (@(posedge clk) disable iff (rst)
    chain_evt |-> desc_evt); // R8
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    paused |-> (!mem_req && !xfer_valid)); // R9
endmodule

bind chain_dma_fetch chain_dma_fetch_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en),
  .mem_req(mem_req), .mem_addr(mem_addr),
  .xfer_valid(xfer_valid), .xfer_done(xfer_done),
  .xfer_src(xfer_src), .xfer_dst(xfer_dst),
  .paused(paused_w), .desc_evt(desc_evt), .chain_evt(chain_evt)
);

// File: tb/chain_dma_fetch_tb.sv
`timescale 1ns/1ps
module chain_dma_fetch_tb;
  localparam logic [31:0] ENDP = 32'hFFFF_F800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [5:0]  cfg_wr_off = '0;
  logic [31:0] cfg_wr_data = '0;
  logic [5:0]  cfg_rd_off = '0;
  logic [31:0] cfg_rd_data;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;
  logic        xfer_valid;
  logic [31:0] xfer_cfg, xfer_src, xfer_dst, xfer_len;
  logic        xfer_src_fixed, xfer_dst_fixed;
  logic [4:0]  xfer_src_beats, xfer_dst_beats;
  logic [2:0]  xfer_src_bytes, xfer_dst_bytes;
  logic        xfer_adv;
  logic [7:0]  xfer_adv_bytes;
  logic        xfer_done;
  logic        desc_evt, chain_evt;

  always #5 clk = ~clk;

  chain_dma_fetch u_dut (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_off(cfg_wr_off), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_off(cfg_rd_off), .cfg_rd_data(cfg_rd_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_cfg(xfer_cfg), .xfer_src(xfer_src), .xfer_dst(xfer_dst),
    .xfer_len(xfer_len),
    .xfer_src_fixed(xfer_src_fixed), .xfer_src_beats(xfer_src_beats), .xfer_src_bytes(xfer_src_bytes),
    .xfer_dst_fixed(xfer_dst_fixed), .xfer_dst_beats(xfer_dst_beats), .xfer_dst_bytes(xfer_dst_bytes),
    .xfer_adv(xfer_adv), .xfer_adv_bytes(xfer_adv_bytes), .xfer_done(xfer_done),
    .desc_evt(desc_evt), .chain_evt(chain_evt)
  );

  typedef struct {
    logic [31:0] cfg, src, dst, len, para;
    bit          last;
    int          adv_n;
    int          adv_b;
  } hand_t;

  logic [31:0] mem [0:255];
  logic [31:0] exp_addr[$];
  hand_t       exp_hand[$];
  int          checks = 0, failures = 0;
  int          rsp_lat = 1;
  int          desc_cnt = 0, chain_cnt = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input int sl, input int sio, input int sb, input int sw,
                                        input int dl, input int dio, input int db, input int dw);
    logic [15:0] s, d;
    s = 16'((sl & 31) | ((sio & 1) << 5) | ((sb & 3) << 7) | ((sw & 3) << 9));
    d = 16'((dl & 31) | ((dio & 1) << 5) | ((db & 3) << 7) | ((dw & 3) << 9));
    return {d, s};
  endfunction

  function automatic int exp_beats(input logic [1:0] c);
    if (c == 2'd0) return 1;
    if (c == 2'd2) return 8;
    return 0;
  endfunction

  function automatic int exp_bytes(input logic [1:0] c);
    if (c == 2'd0) return 1;
    if (c == 2'd1) return 2;
    if (c == 2'd2) return 4;
    return 0;
  endfunction

  // driver: place a descriptor and push what the design must do with it
  task automatic put_desc(input logic [31:0] base, input logic [31:0] cfg, input logic [31:0] src,
                          input logic [31:0] dst, input logic [31:0] len, input logic [31:0] para,
                          input logic [31:0] nxt, input int adv_n, input int adv_b);
    hand_t h;
    logic [31:0] w [6];
    w[0] = cfg; w[1] = src; w[2] = dst; w[3] = len; w[4] = para; w[5] = nxt;
    for (int i = 0; i < 6; i++) begin
      mem[8'((base >> 2) + 32'(i))] = w[i];
      exp_addr.push_back(base + 32'(4 * i));
    end
    h.cfg = cfg; h.src = src; h.dst = dst; h.len = len; h.para = para;
    h.last = (nxt == ENDP); h.adv_n = adv_n; h.adv_b = adv_b;
    exp_hand.push_back(h);
  endtask

  task automatic wr(input logic [5:0] off, input logic [31:0] data);
    cfg_wr_en = 1'b1; cfg_wr_off = off; cfg_wr_data = data;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] off, output logic [31:0] data);
    cfg_rd_off = off;
    @(posedge clk); #1;
    data = cfg_rd_data;
  endtask

  task automatic wait_chain(input int target);
    int n = 0;
    while (chain_cnt < target && n < 3000) begin @(posedge clk); #1; n++; end
    chk(chain_cnt == target, "R8 chain completion count", 32'(chain_cnt), 32'(target));
  endtask

  task automatic wait_req();
    int n = 0;
    while (!mem_req && n < 100) begin @(posedge clk); #1; n++; end
  endtask

  task automatic quiet_window(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (mem_req || xfer_valid) seen = 1'b1;
    end
    chk(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // memory responder / address monitor
  initial begin
    mem_rvalid = 1'b0;
    mem_rdata  = '0;
    @(posedge clk); #1;
    forever begin
      if (!mem_req) begin
        @(posedge clk); #1;
      end else begin
        logic [31:0] a;
        bit again;
        a = mem_addr;
        again = 1'b0;
        if (exp_addr.size() == 0) chk(1'b0, "R2 unexpected read", a, 32'hFFFF_FFFF);
        else begin
          logic [31:0] e;
          e = exp_addr.pop_front();
          chk(a == e, "R2 read address order", a, e);
        end
        for (int k = 0; k < rsp_lat; k++) begin
          @(posedge clk); #1;
          if (mem_req) again = 1'b1;
        end
        chk(!again, "R2 request while read outstanding", 32'(again), 32'd0);
        mem_rvalid = 1'b1;
        mem_rdata  = mem[a[9:2]];
        @(posedge clk); #1;
        mem_rvalid = 1'b0;
      end
    end
  end

  // data mover model / handoff monitor
  initial begin
    xfer_done = 1'b0; xfer_adv = 1'b0; xfer_adv_bytes = '0;
    forever begin
      @(posedge clk); #1;
      if (xfer_valid) begin
        if (exp_hand.size() == 0) begin
          chk(1'b0, "R4 unexpected handoff", xfer_src, 32'hFFFF_FFFF);
        end else begin
          hand_t h;
          int rem;
          h = exp_hand.pop_front();
          chk(xfer_cfg == h.cfg, "R4 handoff config", xfer_cfg, h.cfg);
          chk(xfer_src == h.src, "R4 handoff source", xfer_src, h.src);
          chk(xfer_dst == h.dst, "R4 handoff destination", xfer_dst, h.dst);
          chk(xfer_len == h.len, "R5 count loaded with length", xfer_len, h.len);
          chk(32'(xfer_src_beats) == 32'(exp_beats(h.cfg[8:7])), "R6 source beats",
              32'(xfer_src_beats), 32'(exp_beats(h.cfg[8:7])));
          chk(32'(xfer_src_bytes) == 32'(exp_bytes(h.cfg[10:9])), "R6 source width",
              32'(xfer_src_bytes), 32'(exp_bytes(h.cfg[10:9])));
          chk(32'(xfer_dst_beats) == 32'(exp_beats(h.cfg[24:23])), "R6 destination beats",
              32'(xfer_dst_beats), 32'(exp_beats(h.cfg[24:23])));
          chk(32'(xfer_dst_bytes) == 32'(exp_bytes(h.cfg[26:25])), "R6 destination width",
              32'(xfer_dst_bytes), 32'(exp_bytes(h.cfg[26:25])));
          chk({xfer_src_fixed, xfer_dst_fixed} == {h.cfg[5], h.cfg[21]}, "R6 fixed-address flags",
              32'({xfer_src_fixed, xfer_dst_fixed}), 32'({h.cfg[5], h.cfg[21]}));
          rem = int'(h.len);
          for (int i = 0; i < h.adv_n; i++) begin
            xfer_adv = 1'b1; xfer_adv_bytes = 8'(h.adv_b);
            @(posedge clk); #1;
            rem = (rem < h.adv_b) ? 0 : rem - h.adv_b;
          end
          xfer_adv = 1'b0;
          chk(xfer_len == 32'(rem), "R5 remaining count after progress", xfer_len, 32'(rem));
          xfer_done = 1'b1;
          while (!xfer_valid) begin @(posedge clk); #1; end
          @(posedge clk); #1;
          xfer_done = 1'b0;
          chk(desc_evt == 1'b1, "R7 descriptor event after done", 32'(desc_evt), 32'd1);
          chk(chain_evt == h.last, "R8 chain event only on end marker", 32'(chain_evt), 32'(h.last));
        end
      end
    end
  end

  // event monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (!rst) begin
        if (desc_evt) desc_cnt++;
        if (chain_evt) begin
          chain_cnt++;
          if (!desc_evt) chk(1'b0, "R8 chain event without descriptor event", 32'd0, 32'd1);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] c0, c1, c2;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1: reset state
    chk(!mem_req && !xfer_valid && !desc_evt && !chain_evt, "R1 outputs idle after reset",
        32'({mem_req, xfer_valid, desc_evt, chain_evt}), 32'd0);
    rd(6'h00, v); chk(v == 0, "R1 enable reads 0", v, 0);
    rd(6'h18, v); chk(v == 0, "R1 count reads 0", v, 0);
    rd(6'h08, v); chk(v == 0, "R1 first address reads 0", v, 0);

    // three-descriptor chain, misaligned pointers (R2, R3, R5, R6, R7, R8)
    c0 = mkcfg(1, 0, 0, 0, 7, 1, 2, 2);
    c1 = mkcfg(3, 1, 1, 3, 9, 0, 3, 1);
    c2 = mkcfg(2, 0, 2, 2, 1, 0, 0, 1);
    put_desc(32'h40, c0, 32'h1000, 32'h2000, 32'd64,  32'h8, 32'h83, 2, 16);
    put_desc(32'h80, c1, 32'h1100, 32'h2100, 32'd20,  32'h9, 32'hC1, 3, 8);
    put_desc(32'hC0, c2, 32'h1200, 32'h2200, 32'd100, 32'hA, ENDP,   3, 8);
    wr(6'h08, 32'h42);
    wr(6'h00, 32'h1);
    wait_chain(1);
    chk(desc_cnt == 3, "R7 one event per descriptor", 32'(desc_cnt), 32'd3);
    rd(6'h00, v); chk(v == 0, "R8 idle after end marker", v, 0);
    rd(6'h0C, v); chk(v == c2, "R3 config readback", v, c2);
    rd(6'h10, v); chk(v == 32'h1200, "R3 source readback", v, 32'h1200);
    rd(6'h14, v); chk(v == 32'h2200, "R3 destination readback", v, 32'h2200);
    rd(6'h18, v); chk(v == 32'd76, "R5 remaining count readback", v, 32'd76);
    rd(6'h1C, v); chk(v == 32'hA, "R3 parameter readback", v, 32'hA);
    rd(6'h08, v); chk(v == 32'h42, "R12 first address reads as written", v, 32'h42);
    rd(6'h20, v); chk(v == 0, "R12 unmapped offset reads 0", v, 0);

    // freeze before start (R9, R12)
    put_desc(32'h100, mkcfg(0, 0, 2, 2, 0, 0, 2, 2), 32'h3000, 32'h4000, 32'd8, 32'h1, ENDP, 1, 8);
    wr(6'h04, 32'h2);
    wr(6'h08, 32'h100);
    wr(6'h00, 32'h1);
    quiet_window(8, "R9 no activity while frozen before start");
    rd(6'h00, v); chk(v == 32'h1, "R12 busy bit while frozen", v, 32'h1);
    rd(6'h04, v); chk(v == 32'h2, "R12 pause bit reads back", v, 32'h2);
    wr(6'h04, 32'h0);
    wait_chain(2);

    // freeze in the middle of a fetch (R9)
    rsp_lat = 5;
    put_desc(32'h140, mkcfg(4, 1, 0, 1, 5, 0, 0, 1), 32'h5000, 32'h6000, 32'd12, 32'h2, 32'h180, 0, 0);
    put_desc(32'h180, mkcfg(4, 0, 0, 1, 5, 1, 0, 1), 32'h5100, 32'h6100, 32'd16, 32'h3, ENDP, 0, 0);
    wr(6'h08, 32'h140);
    wr(6'h00, 32'h1);
    wait_req();
    wr(6'h04, 32'h2);
    quiet_window(10, "R9 no request or handoff while frozen mid-fetch");
    wr(6'h04, 32'h0);
    wait_chain(3);
    chk(desc_cnt == 6, "R9 walk resumes without loss", 32'(desc_cnt), 32'd6);

    // stop during a fetch (R10)
    rsp_lat = 6;
    put_desc(32'h200, mkcfg(0, 0, 0, 0, 0, 0, 0, 0), 32'h7000, 32'h7800, 32'd4, 32'h4, ENDP, 0, 0);
    wr(6'h08, 32'h200);
    wr(6'h00, 32'h1);
    wait_req();
    wr(6'h00, 32'h0);
    exp_addr.delete();
    exp_hand.delete();
    quiet_window(12, "R10 nothing after stop, late data ignored");
    rd(6'h00, v); chk(v == 0, "R10 idle after stop", v, 0);
    chk(desc_cnt == 6 && chain_cnt == 3, "R10 no events after stop", 32'(desc_cnt), 32'd6);

    // stop while frozen clears the pause bit (R10)
    put_desc(32'h200, mkcfg(0, 0, 0, 0, 0, 0, 0, 0), 32'h7000, 32'h7800, 32'd4, 32'h4, ENDP, 0, 0);
    wr(6'h00, 32'h1);
    wait_req();
    wr(6'h04, 32'h2);
    wr(6'h00, 32'h0);
    exp_addr.delete();
    exp_hand.delete();
    rd(6'h04, v); chk(v == 0, "R10 stop clears pause", v, 0);
    quiet_window(12, "R10 nothing after stop while frozen");

    // start while busy is ignored (R11)
    rsp_lat = 1;
    put_desc(32'h280, mkcfg(6, 0, 2, 1, 6, 0, 2, 1), 32'h8000, 32'h9000, 32'd32, 32'h5, 32'h2C0, 1, 4);
    put_desc(32'h2C0, mkcfg(6, 0, 0, 2, 6, 0, 0, 2), 32'h8100, 32'h9100, 32'd32, 32'h6, ENDP, 0, 0);
    wr(6'h08, 32'h280);
    wr(6'h00, 32'h1);
    wr(6'h08, 32'h340);
    wr(6'h00, 32'h1);
    wait_chain(4);
    chk(desc_cnt == 8, "R11 running chain unchanged by second start", 32'(desc_cnt), 32'd8);
    chk(exp_addr.size() == 0, "R11 every expected read issued", 32'(exp_addr.size()), 32'd0);
    rd(6'h08, v); chk(v == 32'h340, "R12 first address updated while busy", v, 32'h340);
    quiet_window(6, "R11 no restart after chain end");

    finish_run();
  end
endmodule